// File: doc/BRIEF.md
# Mask-Capable Quasi-Bidirectional Port

This block is an eight-bit general purpose port whose pins are shared between output and input without any direction register. Each pin has one bit in an output latch. A latch bit of 0 pulls the pin hard to ground. A latch bit of 1 only holds the pin up weakly, so an outside device can still pull it low. Software makes a pin an input by writing a 1 to its latch bit and then reading the pin.

One operation is issued per clock. The operation can load the latch with a full byte, clear latch bits through an AND mask, set latch bits through an OR mask, or capture the current pin levels. Pin levels are never stored ahead of a read. The read result is taken from the pins at the clock edge of the read operation. The mask operations change only the bits that the mask selects, and the new value stays on the pins until another operation changes it.

Top module: `mask_port`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every latch bit is 1: `padPullUp` = 8'hFF, `padDriveLow` = 8'h00, `readData` = 8'h00.
- R2: An operation with `opValid`=1 and `opSel`=2'b00 (load) places `loadData` in the latch. The new value is visible on the pad outputs one clock later.
- R3: An operation with `opSel`=2'b01 (AND) makes the latch the bitwise AND of its old value and `maskData`, in one clock.
- R4: An operation with `opSel`=2'b10 (OR) makes the latch the bitwise OR of its old value and `maskData`, in one clock.
- R5: For every bit, `padDriveLow` is the inverse of the latch bit and `padPullUp` equals the latch bit. A pin is never both driven low and pulled up.
- R6: An operation with `opSel`=2'b11 (read) loads `padIn`, as sampled at that clock edge, into `readData` one clock later. A read leaves the latch unchanged.
- R7: A read returns the levels on the pins, not the latch contents. A pin whose latch bit is 1 but which is held low from outside reads as 0.
- R8: When `opValid` is 0, neither the latch nor `readData` changes, whatever `opSel`, `loadData`, `maskData` or `padIn` carry. `maskData` has no effect on a load or a read, and `loadData` has no effect on AND or OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is issued this cycle |
| opSel | input | 2 | 00 load, 01 AND mask, 10 OR mask, 11 read pins |
| loadData | input | 8 | Byte for the load operation |
| maskData | input | 8 | Immediate mask for AND and OR |
| padIn | input | 8 | Levels currently on the pins |
| padDriveLow | output | 8 | Strong pull-down enable per pin |
| padPullUp | output | 8 | Weak pull-up enable per pin (equals the latch) |
| readData | output | 8 | Pin levels captured by the last read |

## Verification
The latch is the only state that reaches the pins. A corrupted latch bit therefore shows up on `padPullUp` and `padDriveLow` on the cycle after the faulty update. Because the bench checks both outputs after every clock, a wrong load, a mask applied with the wrong polarity, or a read that disturbs the latch is caught on that same cycle. A fault in the read path shows up in `readData` one cycle after the read. The bench pulls pins low from outside while their latch bits are 1, so a read that returns the latch instead of the pins produces a visible mismatch.

// File: rtl/mask_port_pkg.sv
package mask_port_pkg;

  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_AND  = 2'b01,
    OP_OR   = 2'b10,
    OP_READ = 2'b11
  } portOp_e;

  typedef struct packed {
    logic latchLoad;
    logic latchAnd;
    logic latchOr;
    logic sampleIn;
  } portStrobe_t;

endpackage

// File: rtl/mask_port_ctrl.sv
module mask_port_ctrl
  import mask_port_pkg::*;
(
  input  logic        opValid,
  input  logic [1:0]  opSel,
  output portStrobe_t strb
);

  always_comb begin
    strb = '0;
    if (opValid) begin
      unique case (portOp_e'(opSel))
        OP_LOAD: strb.latchLoad = 1'b1;
        OP_AND:  strb.latchAnd  = 1'b1;
        OP_OR:   strb.latchOr   = 1'b1;
        OP_READ: strb.sampleIn  = 1'b1;
        default: strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/mask_port_dp.sv
module mask_port_dp
  import mask_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  portStrobe_t  strb,
  input  logic [W-1:0] loadData,
  input  logic [W-1:0] maskData,
  input  logic [W-1:0] padIn,
  output logic [W-1:0] padDriveLow,
  output logic [W-1:0] padPullUp,
  output logic [W-1:0] readData
);

  localparam logic [W-1:0] LatchReset = '1;

  logic [W-1:0] latchQ;
  logic [W-1:0] latchNext;
  logic [W-1:0] readQ;

  always_comb begin
    latchNext = latchQ;
    if (strb.latchLoad)     latchNext = loadData;
    else if (strb.latchAnd) latchNext = latchQ & maskData;
    else if (strb.latchOr)  latchNext = latchQ | maskData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchQ <= LatchReset;
    else       latchQ <= latchNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              readQ <= '0;
    else if (strb.sampleIn) readQ <= padIn;
  end

  for (genvar b = 0; b < W; b++) begin : g_pad
    assign padPullUp[b]   = latchQ[b];
    assign padDriveLow[b] = ~latchQ[b];
  end

  assign readData = readQ;

endmodule

// File: rtl/mask_port.sv
module mask_port
  import mask_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         opValid,
  input  logic [1:0]   opSel,
  input  logic [W-1:0] loadData,
  input  logic [W-1:0] maskData,
  input  logic [W-1:0] padIn,
  output logic [W-1:0] padDriveLow,
  output logic [W-1:0] padPullUp,
  output logic [W-1:0] readData
);

  portStrobe_t strb;

  mask_port_ctrl u_ctrl (
    .opValid (opValid),
    .opSel   (opSel),
    .strb    (strb)
  );

  mask_port_dp #(.W(W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .loadData    (loadData),
    .maskData    (maskData),
    .padIn       (padIn),
    .padDriveLow (padDriveLow),
    .padPullUp   (padPullUp),
    .readData    (readData)
  );

endmodule

// File: rtl/mask_port_chk.sv
module mask_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         opValid,
  input logic [1:0]   opSel,
  input logic [W-1:0] loadData,
  input logic [W-1:0] maskData,
  input logic [W-1:0] padIn,
  input logic [W-1:0] padDriveLow,
  input logic [W-1:0] padPullUp,
  input logic [W-1:0] readData
);

  // R1
  reset_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padPullUp == '1 && readData == '0));

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 2'b00) |=> padPullUp == $past(loadData));

  // R3
  and_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 2'b01) |=> padPullUp == ($past(padPullUp) & $past(maskData)));

  // R4
  or_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 2'b10) |=> padPullUp == ($past(padPullUp) | $past(maskData)));

  // R5
  pad_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padDriveLow & padPullUp) == '0 && (padDriveLow | padPullUp) == '1);

  // R6
  read_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 2'b11) |=> (readData == $past(padIn) && $stable(padPullUp)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(padPullUp) && $stable(readData)));

endmodule

bind mask_port mask_port_chk #(.W(W)) u_chk (.*);

// File: tb/mask_port_test.sv
module mask_port_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [1:0] opSel = 2'b00;
  logic [7:0] loadData = 8'h00;
  logic [7:0] maskData = 8'h00;
  logic [7:0] extLow = 8'h00;
  logic [7:0] padIn;
  logic [7:0] padDriveLow;
  logic [7:0] padPullUp;
  logic [7:0] readData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] refLatch = 8'hFF;
  logic [7:0] refRead  = 8'h00;

  always #2.5 clk = ~clk;

  // open-drain style wire: high only if pulled up and not held low outside
  assign padIn = padPullUp & ~extLow;

  mask_port uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .loadData(loadData), .maskData(maskData), .padIn(padIn),
    .padDriveLow(padDriveLow), .padPullUp(padPullUp), .readData(readData)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check({tag, " pullUp"},    padPullUp,   refLatch);
    check({tag, " driveLow"},  padDriveLow, ~refLatch);
    check({tag, " readData"},  readData,    refRead);
  endtask

  // drive one cycle, advance the model, compare away from the edge
  task automatic step(input string tag, input logic v, input logic [1:0] s,
                      input logic [7:0] ld, input logic [7:0] mk, input logic [7:0] ext);
    logic [7:0] pinsNow;
    opValid = v; opSel = s; loadData = ld; maskData = mk; extLow = ext;
    pinsNow = refLatch & ~ext;
    @(posedge clk);
    if (v) begin
      case (s)
        2'b00: refLatch = ld;
        2'b01: refLatch = refLatch & mk;
        2'b10: refLatch = refLatch | mk;
        default: refRead = pinsNow;
      endcase
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 after reset");

    step("R2 load A5",  1, 2'b00, 8'hA5, 8'h0F, 8'h00);
    step("R2 load 3C",  1, 2'b00, 8'h3C, 8'hFF, 8'h00);
    step("R3 and F0",   1, 2'b01, 8'h00, 8'hF0, 8'h00);
    step("R3 and 00",   1, 2'b01, 8'hFF, 8'h00, 8'h00);
    step("R4 or 81",    1, 2'b10, 8'h00, 8'h81, 8'h00);
    step("R4 or 7E",    1, 2'b10, 8'h00, 8'h7E, 8'h00);
    step("R5 load 5A",  1, 2'b00, 8'h5A, 8'h00, 8'h00);
    step("R6 read",     1, 2'b11, 8'h00, 8'h00, 8'h00);
    step("R4 set FF",   1, 2'b10, 8'h12, 8'hFF, 8'h00);
    step("R7 read ext", 1, 2'b11, 8'hFF, 8'hFF, 8'h96);
    step("R7 read ext2",1, 2'b11, 8'h00, 8'h00, 8'h0F);
    step("R8 idle",     0, 2'b00, 8'h00, 8'h00, 8'hFF);
    step("R8 idle and", 0, 2'b01, 8'h00, 8'h00, 8'h00);
    step("R8 idle read",0, 2'b11, 8'h00, 8'h00, 8'hAA);
    step("R8 and ignores load", 1, 2'b01, 8'h00, 8'hCC, 8'h00);
    step("R6 read holds latch", 1, 2'b11, 8'h00, 8'h00, 8'h40);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a = 8'(i * 37 + 11);
      logic [7:0] m = 8'(i * 91 + 5);
      step("R2-mix", 1'(i % 5 != 4), 2'(i % 4), a, m, 8'(i * 13));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule